// File: doc/BRIEF.md
# SDRAM Bank and Data-Bus Tracker with Concurrent Auto Precharge

This block watches the command stream that a controller has already registered toward a four-bank SDRAM. It keeps a cycle-accurate picture of every bank and of the shared data bus. Each command (activate, read, write, precharge or no-op) carries a bank number, an auto-precharge flag and the current DQM level. From these the tracker derives, for each bank, whether it is idle, holding an open row, bursting reads, bursting writes, or precharging. It also pulses when a bank's precharge interval begins, and marks every read beat that actually reaches the bus.

The block models the case where an access to one bank cuts short a read with auto precharge running on another bank. The interrupted bank starts its precharge interval at the edge that registers the interrupting command. Its burst does not run to completion. A read that interrupts hands the bus over once the CAS latency has passed. A write that interrupts drops every read beat still in flight, and the block flags bus contention when the beat that lands on the write's edge was not masked by DQM two edges earlier. When concurrent auto precharge is switched off, the tracker flags such cross-bank accesses instead. Commands that are illegal for the target bank's state set a sticky error.

Top module: `sdram_ap_tracker`

## Requirements
- R1: While rst_ni is low, and after it is released, every bank reports idle (code 0), and rd_valid_o, contention_o, ap_conflict_o, err_o and every pre_start_o bit are 0. Bank b's state is on bank_state_o[3b+2:3b] with codes idle=0, active=1, read=2, write=3, precharging=4. Commands on cmd_i are encoded nop=0, activate=1, read=2, write=3, precharge=4.
- R2: An activate to an idle bank makes it active from the next cycle. A precharge to an active bank makes it precharging for TRP cycles (3 by default) and then idle. pre_start_o for that bank is high only in the first precharging cycle.
- R3: A read registered at edge k shows the bank as read for BL cycles (4), then active if auto precharge was off. rd_valid_o is high in the cycles after edges k+CL through k+CL+BL-1 (CL=3), with rd_bank_o giving the bank.
- R4: A read with auto precharge that is not interrupted enters precharging after its BL read cycles. It stays precharging for TRP cycles, then goes idle, and pre_start_o pulses in its first precharging cycle.
- R5: A write with auto precharge shows write for BL cycles, then precharging for TWR+TRP cycles (5 by default), then idle. A write produces no rd_valid_o.
- R6: A read to bank m registered at edge k' while bank n runs a read with auto precharge makes bank n precharging, with its pre_start_o bit high, from edge k'. Bank n's beats still appear for slots before k'+CL, and bank m's beats follow from slot k'+CL.
- R7: A write registered at edge k' interrupts any read: the interrupted auto-precharge bank is precharging from edge k'. rd_valid_o stays low from edge k' until a later read's data arrives.
- R8: contention_o is high for the one cycle after a write's edge when a read beat was due on that edge and DQM was low at the edge two before it. It stays low when DQM was high there.
- R9: A read beat due at slot s is suppressed (rd_valid_o low) when dqm_i was high at edge s-2.
- R10: With cap_en_i low, a read or write to a bank other than one in an auto-precharge burst sets the sticky ap_conflict_o. With cap_en_i high, ap_conflict_o stays low.
- R11: A read or write to an idle bank, or an activate, read or write to a precharging bank, sets the sticky err_o and does not change that bank's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Registered command code |
| bank_i | input | 2 | Target bank |
| ap_i | input | 1 | Auto-precharge flag of a read or write |
| dqm_i | input | 1 | Data mask level this cycle |
| cap_en_i | input | 1 | Concurrent auto precharge enabled |
| bank_state_o | output | 12 | Three-bit state per bank |
| pre_start_o | output | 4 | Precharge-start pulse per bank |
| rd_valid_o | output | 1 | Read beat on the data bus |
| rd_bank_o | output | 2 | Bank of the current read beat |
| contention_o | output | 1 | Read beat collided with write data |
| ap_conflict_o | output | 1 | Sticky: cross-bank access with concurrent auto precharge disabled |
| err_o | output | 1 | Sticky: command illegal for bank state |

## Verification
A wrong bank state shows on bank_state_o in the cycle after the command edge that caused it. A precharge interval with the wrong length surfaces TRP or TWR+TRP cycles later, when the idle code arrives early or late. Errors in the read pipeline appear only CL cycles after the read: a beat that is missing, extra or from the wrong bank shows on rd_valid_o and rd_bank_o. A wrong DQM delay shows as a beat masked in the wrong slot, or as contention_o at the wrong level one cycle after the interrupting write.

// File: rtl/sdram_ap_pkg.sv
`timescale 1ns/1ps
package sdram_ap_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_ACT = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3, CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE = 3'd0, BS_ACT = 3'd1, BS_RD = 3'd2, BS_WR = 3'd3, BS_PRE = 3'd4
  } bstate_e;
endpackage

// File: rtl/sdram_ap_bank.sv
`timescale 1ns/1ps
module sdram_ap_bank
  import sdram_ap_pkg::*;
#(
  parameter int BL  = 4,
  parameter int TRP = 3,
  parameter int TWR = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cmd_e    cmd_i,
  input  logic    sel_i,
  input  logic    other_acc_i,
  input  logic    ap_i,
  input  logic    cap_en_i,
  output bstate_e state_o,
  output logic    pre_start_o,
  output logic    err_o,
  output logic    conflict_o
);
  localparam int WPRE  = TWR + TRP;
  localparam int MAXC  = (BL > WPRE) ? BL : WPRE;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] BL_M1 = CW'(BL - 1);
  localparam logic [CW-1:0] RP_M1 = CW'(TRP - 1);
  localparam logic [CW-1:0] WP_M1 = CW'(WPRE - 1);

  bstate_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic ap_q, ap_d, ps_q, ps_d;
  logic own_acc, err;

  assign own_acc = sel_i && (cmd_i == CMD_RD || cmd_i == CMD_WR);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ap_d  = ap_q;
    ps_d  = 1'b0;
    err   = 1'b0;
    unique case (st_q)
      BS_IDLE: begin
        if (sel_i && cmd_i == CMD_ACT) st_d = BS_ACT;
        else if (own_acc) err = 1'b1;
      end
      BS_ACT, BS_RD, BS_WR: begin
        if (own_acc) begin
          st_d  = (cmd_i == CMD_RD) ? BS_RD : BS_WR;
          cnt_d = BL_M1;
          ap_d  = ap_i;
        end else if (sel_i && cmd_i == CMD_PRE) begin
          st_d  = BS_PRE;
          cnt_d = RP_M1;
          ap_d  = 1'b0;
          ps_d  = 1'b1;
        end else if (st_q != BS_ACT) begin
          // burst ends naturally or is cut by an access elsewhere
          if (other_acc_i || cnt_q == '0) begin
            if (ap_q) begin
              st_d  = BS_PRE;
              cnt_d = (st_q == BS_RD) ? RP_M1 : WP_M1;
              ps_d  = 1'b1;
            end else begin
              st_d = BS_ACT;
            end
            ap_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      BS_PRE: begin
        if (sel_i && (cmd_i == CMD_ACT || own_acc)) err = 1'b1;
        if (cnt_q == '0) st_d = BS_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
      ap_q  <= 1'b0;
      ps_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ap_q  <= ap_d;
      ps_q  <= ps_d;
    end
  end

  assign state_o     = st_q;
  assign pre_start_o = ps_q;
  assign err_o       = err;
  assign conflict_o  = !cap_en_i && other_acc_i && ap_q && (st_q == BS_RD || st_q == BS_WR);

  assert_pre_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_PRE) |=> (st_q == BS_PRE || st_q == BS_IDLE));
  assert_pre_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_start_o |-> (state_o == BS_PRE));
  assert_rd_intr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_RD && ap_q && other_acc_i) |=> (state_o == BS_PRE && pre_start_o));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BS_IDLE && err_o) |=> (state_o == BS_IDLE));
endmodule

// File: rtl/sdram_ap_dbus.sv
`timescale 1ns/1ps
module sdram_ap_dbus
  import sdram_ap_pkg::*;
#(
  parameter int BW = 2,
  parameter int BL = 4,
  parameter int CL = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic [BW-1:0] bank_i,
  input  logic          dqm_i,
  output logic          rd_valid_o,
  output logic [BW-1:0] rd_bank_o,
  output logic          contention_o
);
  localparam int BCW = $clog2(BL + 1);
  localparam logic [BCW-1:0] BL_M1 = BCW'(BL - 1);

  logic [BCW-1:0] iss_cnt_q, iss_cnt_d;
  logic [BW-1:0]  iss_bank_q, iss_bank_d, beat_b;
  logic           beat_v, wr, head_live;
  logic           dv_q [CL];
  logic [BW-1:0]  db_q [CL];
  logic           dqm_q1, dqm_q2, rv_q, ct_q;
  logic [BW-1:0]  rb_q;

  // issue side: one beat per cycle of the active read burst
  always_comb begin
    beat_v     = 1'b0;
    beat_b     = iss_bank_q;
    iss_cnt_d  = iss_cnt_q;
    iss_bank_d = iss_bank_q;
    if (cmd_i == CMD_RD) begin
      beat_v     = 1'b1;
      beat_b     = bank_i;
      iss_cnt_d  = BL_M1;
      iss_bank_d = bank_i;
    end else if (cmd_i == CMD_WR) begin
      iss_cnt_d = '0;
    end else if (iss_cnt_q != '0) begin
      beat_v    = 1'b1;
      iss_cnt_d = iss_cnt_q - 1'b1;
    end
  end

  assign wr        = (cmd_i == CMD_WR);
  assign head_live = dv_q[CL-1] && !dqm_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_cnt_q  <= '0;
      iss_bank_q <= '0;
      for (int i = 0; i < CL; i++) begin
        dv_q[i] <= 1'b0;
        db_q[i] <= '0;
      end
      dqm_q1 <= 1'b0;
      dqm_q2 <= 1'b0;
      rv_q   <= 1'b0;
      rb_q   <= '0;
      ct_q   <= 1'b0;
    end else begin
      iss_cnt_q  <= iss_cnt_d;
      iss_bank_q <= iss_bank_d;
      dv_q[0]    <= beat_v;
      db_q[0]    <= beat_b;
      for (int i = 1; i < CL; i++) begin
        dv_q[i] <= dv_q[i-1] && !wr;  // write flushes later beats
        db_q[i] <= db_q[i-1];
      end
      dqm_q1 <= dqm_i;
      dqm_q2 <= dqm_q1;
      rv_q   <= head_live && !wr;
      rb_q   <= db_q[CL-1];
      ct_q   <= head_live && wr;
    end
  end

  assign rd_valid_o   = rv_q;
  assign rd_bank_o    = rb_q;
  assign contention_o = ct_q;

  assert_dqm_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !$past(dqm_i, 3));
  assert_wr_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_WR) |=> !rd_valid_o);
  assert_cont_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_WR) |=> !contention_o);
endmodule

// File: rtl/sdram_ap_tracker.sv
`timescale 1ns/1ps
module sdram_ap_tracker
  import sdram_ap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BL        = 4,
  parameter int CL        = 3,
  parameter int TRP       = 3,
  parameter int TWR       = 2,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             cmd_i,
  input  logic [BW-1:0]          bank_i,
  input  logic                   ap_i,
  input  logic                   dqm_i,
  input  logic                   cap_en_i,
  output logic [NUM_BANKS*3-1:0] bank_state_o,
  output logic [NUM_BANKS-1:0]   pre_start_o,
  output logic                   rd_valid_o,
  output logic [BW-1:0]          rd_bank_o,
  output logic                   contention_o,
  output logic                   ap_conflict_o,
  output logic                   err_o
);
  cmd_e cmd;
  logic is_acc;
  logic [NUM_BANKS-1:0] err_vec, conf_vec;
  logic err_q, conf_q;

  assign cmd    = cmd_e'(cmd_i);
  assign is_acc = (cmd == CMD_RD) || (cmd == CMD_WR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic    sel;
    bstate_e st;
    assign sel = (bank_i == BW'(b));
    sdram_ap_bank #(.BL(BL), .TRP(TRP), .TWR(TWR)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmd_i       (cmd),
      .sel_i       (sel),
      .other_acc_i (is_acc && !sel),
      .ap_i        (ap_i),
      .cap_en_i    (cap_en_i),
      .state_o     (st),
      .pre_start_o (pre_start_o[b]),
      .err_o       (err_vec[b]),
      .conflict_o  (conf_vec[b])
    );
    assign bank_state_o[3*b +: 3] = st;
  end

  sdram_ap_dbus #(.BW(BW), .BL(BL), .CL(CL)) u_dbus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .bank_i       (bank_i),
    .dqm_i        (dqm_i),
    .rd_valid_o   (rd_valid_o),
    .rd_bank_o    (rd_bank_o),
    .contention_o (contention_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      conf_q <= 1'b0;
    end else begin
      err_q  <= err_q | (|err_vec);
      conf_q <= conf_q | (|conf_vec);
    end
  end

  assign err_o         = err_q;
  assign ap_conflict_o = conf_q;

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_conf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_conflict_o |=> ap_conflict_o);
  assert_conf_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_en_i && !ap_conflict_o) |=> !ap_conflict_o);
endmodule

// File: tb/sdram_ap_tracker_tb.sv
`timescale 1ns/1ps
module sdram_ap_tracker_tb_top;
  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4;
  localparam int S_IDLE = 0, S_ACT = 1, S_RD = 2, S_WR = 3, S_PRE = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [1:0] bank_i = '0;
  logic ap_i = 1'b0, dqm_i = 1'b0, cap_en_i = 1'b1;
  logic [11:0] bank_state_o;
  logic [3:0] pre_start_o;
  logic rd_valid_o, contention_o, ap_conflict_o, err_o;
  logic [1:0] rd_bank_o;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sdram_ap_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .bank_i(bank_i), .ap_i(ap_i),
    .dqm_i(dqm_i), .cap_en_i(cap_en_i), .bank_state_o(bank_state_o),
    .pre_start_o(pre_start_o), .rd_valid_o(rd_valid_o), .rd_bank_o(rd_bank_o),
    .contention_o(contention_o), .ap_conflict_o(ap_conflict_o), .err_o(err_o)
  );

  function automatic int st(input int b);
    return int'(bank_state_o[3*b +: 3]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int c, input int b, input bit ap, input bit dq);
    cmd_i = 3'(c); bank_i = 2'(b); ap_i = ap; dqm_i = dq;
    @(posedge clk); @(negedge clk);
    cmd_i = '0; ap_i = 1'b0; dqm_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; cap_en_i = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int b = 0; b < 4; b++) chk("R1 state", st(b), S_IDLE);
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 flags", {contention_o, ap_conflict_o, err_o}, 0);
    chk("R1 pre_start", pre_start_o, 0);
  endtask

  task automatic t_act_pre();
    do_reset();
    step(ACT, 1, 0, 0);
    chk("R2 active", st(1), S_ACT);
    step(PRE, 1, 0, 0);
    chk("R2 pre", st(1), S_PRE);
    chk("R2 pre_start", pre_start_o, 4'b0010);
    for (int i = 1; i <= 3; i++) begin
      step(NOP, 0, 0, 0);
      chk("R2 pre len", st(1), (i < 3) ? S_PRE : S_IDLE);
      chk("R2 pulse one", pre_start_o, 0);
    end
  endtask

  task automatic t_read_plain();
    do_reset();
    step(ACT, 0, 0, 0);
    for (int i = 0; i <= 7; i++) begin
      step(i == 0 ? RD : NOP, 0, 0, 0);
      chk("R3 valid", rd_valid_o, (i >= 3 && i <= 6) ? 1 : 0);
      if (i >= 3 && i <= 6) chk("R3 bank", rd_bank_o, 0);
      chk("R3 state", st(0), (i <= 3) ? S_RD : S_ACT);
    end
  endtask

  task automatic t_read_ap();
    do_reset();
    step(ACT, 2, 0, 0);
    for (int i = 0; i <= 7; i++) begin
      step(i == 0 ? RD : NOP, 2, i == 0, 0);
      chk("R4 state", st(2), (i <= 3) ? S_RD : (i <= 6) ? S_PRE : S_IDLE);
      chk("R4 pre_start", pre_start_o[2], (i == 4) ? 1 : 0);
      chk("R4 valid", rd_valid_o, (i >= 3 && i <= 6) ? 1 : 0);
    end
  endtask

  task automatic t_write_ap();
    do_reset();
    step(ACT, 3, 0, 0);
    for (int i = 0; i <= 9; i++) begin
      step(i == 0 ? WR : NOP, 3, i == 0, 0);
      chk("R5 state", st(3), (i <= 3) ? S_WR : (i <= 8) ? S_PRE : S_IDLE);
      chk("R5 no read", rd_valid_o, 0);
    end
  endtask

  task automatic t_rd_intr();
    do_reset();
    step(ACT, 0, 0, 0);
    step(ACT, 1, 0, 0);
    for (int i = 0; i <= 9; i++) begin
      if (i == 0) step(RD, 0, 1, 0);
      else if (i == 2) step(RD, 1, 0, 0);
      else step(NOP, 0, 0, 0);
      chk("R6 valid", rd_valid_o, (i >= 3 && i <= 8) ? 1 : 0);
      if (i >= 3 && i <= 8) chk("R6 bank", rd_bank_o, (i <= 4) ? 0 : 1);
      chk("R6 bank n", st(0), (i <= 1) ? S_RD : (i <= 4) ? S_PRE : S_IDLE);
      chk("R6 pre_start", pre_start_o[0], (i == 2) ? 1 : 0);
      if (i >= 2) chk("R6 bank m", st(1), (i <= 5) ? S_RD : S_ACT);
    end
    chk("R10 enabled no flag", ap_conflict_o, 0);
  endtask

  task automatic t_wr_intr(input bit masked);
    do_reset();
    step(ACT, 0, 0, 0);
    step(ACT, 1, 0, 0);
    for (int i = 0; i <= 7; i++) begin
      if (i == 0) step(RD, 0, 1, 0);
      else if (i == 3) step(WR, 1, 0, 0);
      else step(NOP, 0, 0, masked && i == 1);
      chk("R7 valid", rd_valid_o, 0);
      chk("R8 contention", contention_o, (!masked && i == 3) ? 1 : 0);
      chk("R7 bank n", st(0), (i <= 2) ? S_RD : (i <= 5) ? S_PRE : S_IDLE);
      if (i == 3) chk("R7 pre_start", pre_start_o[0], 1);
      if (i >= 3) chk("R7 bank m", st(1), (i <= 6) ? S_WR : S_ACT);
    end
  endtask

  task automatic t_dqm();
    do_reset();
    step(ACT, 2, 0, 0);
    for (int i = 0; i <= 7; i++) begin
      step(i == 0 ? RD : NOP, 2, 0, i == 2);
      chk("R9 mask", rd_valid_o, (i == 3 || i == 5 || i == 6) ? 1 : 0);
    end
  endtask

  task automatic t_conflict();
    do_reset();
    cap_en_i = 1'b0;
    step(ACT, 0, 0, 0);
    step(ACT, 1, 0, 0);
    chk("R10 quiet", ap_conflict_o, 0);
    step(RD, 0, 1, 0);
    chk("R10 quiet own", ap_conflict_o, 0);
    step(RD, 1, 0, 0);
    chk("R10 flag", ap_conflict_o, 1);
    step(NOP, 0, 0, 0);
    step(NOP, 0, 0, 0);
    chk("R10 sticky", ap_conflict_o, 1);
    do_reset();
    chk("R10 reset clears", ap_conflict_o, 0);
  endtask

  task automatic t_err();
    do_reset();
    step(RD, 3, 0, 0);
    chk("R11 err", err_o, 1);
    chk("R11 idle kept", st(3), S_IDLE);
    do_reset();
    step(ACT, 1, 0, 0);
    step(PRE, 1, 0, 0);
    step(ACT, 1, 0, 0);
    chk("R11 err pre", err_o, 1);
    chk("R11 pre kept", st(1), S_PRE);
    step(NOP, 0, 0, 0);
    step(NOP, 0, 0, 0);
    chk("R11 sticky", err_o, 1);
    chk("R11 pre done", st(1), S_IDLE);
  endtask

  initial begin
    t_reset();
    t_act_pre();
    t_read_plain();
    t_read_ap();
    t_write_ap();
    t_rd_intr();
    t_wr_intr(1'b1);
    t_wr_intr(1'b0);
    t_dqm();
    t_conflict();
    t_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule